// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel words into asynchronous serial frames on one output line. A host writes a word into a one-entry holding stage. As soon as the shift engine is free and transmission is allowed, the word moves into the shift engine. The holding stage then frees up for the next word, even though the current frame is still going out. Because of this split, a second word can wait while a frame is on the line. That second frame starts the moment the stop bit of the first one ends, with no idle gap between them.

Each frame starts with a low start bit. The data bits follow, least significant first. An optional ninth bit comes after them; it is taken from a separate control input, not from the written word. A high stop bit ends the frame. All bits have the same length, which is set by an 8-bit divisor: one bit lasts divisor+1 clock cycles.

Two status outputs tell the host what it may do. The first shows whether the holding stage can accept a word. The second shows whether the line is quiet.

Top module: `dbuf_uart_tx`

## Requirements
- R1: During and after reset, with `port_en` low, the outputs read `buf_empty`=1, `shift_empty`=1, `tx_out`=1 and `tx_drive`=0.
- R2: A write is accepted when `wr_en` is sampled high at a rising edge while `buf_empty`=1 and `port_en`=1. In that case `buf_empty` reads 0 after that edge. If the shift engine is idle and `tx_en`=1, the word moves into it at the next edge. `buf_empty` then returns to 1, `shift_empty` drops to 0, and the start bit begins.
- R3: A write while `buf_empty`=0 is ignored. The held word is kept, `buf_empty` stays 0, and no extra frame is sent.
- R4: A frame is a start bit (0), then the data bits with bit 0 first, then a stop bit (1). Each bit lasts divisor+1 cycles. In 8-bit mode `shift_empty` stays low for 10×(divisor+1) cycles.
- R5: When `nine_mode`=1, the value of `ninth_bit` is captured at the moment of transfer and sent after data bit 7. The frame is then 11 bit times long.
- R6: If a word is held when a stop bit ends, its start bit follows at once. In 8-bit mode the two start bits are 10×(divisor+1) cycles apart, and `shift_empty` stays low the whole time.
- R7: While `shift_empty`=1 the line `tx_out` idles at 1.
- R8: With `tx_en`=0 no held word is moved into the shift engine; it waits with `buf_empty`=0. A frame already in progress still completes.
- R9: `tx_drive` follows `port_en`. While `port_en`=0, writes are ignored. One cycle after `port_en` is cleared, the transmitter is idle and the holding stage is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Serial port enable; clearing it flushes the block |
| tx_en | input | 1 | Allows transfers from the holding stage to the shift engine |
| nine_mode | input | 1 | Selects 9-data-bit frames |
| ninth_bit | input | 1 | Value sent as the ninth data bit |
| divisor | input | 8 | Bit time minus one, in clock cycles |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Word to send |
| buf_empty | output | 1 | Holding stage can take a word |
| shift_empty | output | 1 | No frame in progress |
| tx_out | output | 1 | Serial line |
| tx_drive | output | 1 | Output-enable for the serial line |

## Verification
The hardest condition to reach from the ports is this one: a second word must already sit in the holding stage at the exact cycle the stop bit ends. This is what checks that a new frame starts with no gap. To get there, the stimulus waits for `buf_empty` to return high after the first transfer. It then writes the second word while the first frame is still in its data bits. Then, while the holding stage is still full, it writes a third word, to show that this write is dropped. A second hard case is clearing `tx_en` in the middle of a frame while a word is held. The bench then checks that the frame on the line still finishes and that the held word stays put until `tx_en` is set again.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;
   typedef enum logic {
      TXS_IDLE = 1'b0,
      TXS_BUSY = 1'b1
   } tx_state_e;
endpackage

// File: rtl/dbtx_baud.sv
module dbtx_baud #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (!run)           cnt <= '0;
      else if (cnt == divisor) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == divisor);
endmodule

// File: rtl/dbtx_hold.sv
module dbtx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full <= 1'b0;
         q    <= '0;
      end else if (clr) begin
         full <= 1'b0;
      end else if (take) begin
         full <= 1'b0;
      end else if (wr_en && !full) begin
         full <= 1'b1;
         q    <= wr_data;
      end
   end
endmodule

// File: rtl/dbtx_shift.sv
module dbtx_shift
   import dbtx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int NINTH_EN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tick,
   input  logic              load_ok,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_q,
   input  logic              nine_mode,
   input  logic              ninth_bit,
   output logic              take,
   output logic              busy,
   output logic              tx_out
);
   localparam int MAXB  = DATA_W + 1 + NINTH_EN;
   localparam int CNT_W = $clog2(MAXB + 1);

   tx_state_e        state;
   logic [MAXB-1:0]  sh, nxt;
   logic [CNT_W-1:0] left, nxt_left;

   generate
      if (NINTH_EN != 0) begin : g_nine
         always_comb begin
            if (nine_mode) begin
               nxt      = {1'b1, ninth_bit, hold_q};
               nxt_left = CNT_W'(MAXB);
            end else begin
               nxt      = {1'b1, 1'b1, hold_q};
               nxt_left = CNT_W'(MAXB - 1);
            end
         end
      end else begin : g_eight
         logic unused_nine;
         assign unused_nine = nine_mode ^ ninth_bit;
         always_comb begin
            nxt      = {1'b1, hold_q};
            nxt_left = CNT_W'(MAXB);
         end
      end
   endgenerate

   assign busy = (state == TXS_BUSY);
   assign take = hold_full && load_ok && (!busy || (tick && left == '0));

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         state  <= TXS_IDLE;
         tx_out <= 1'b1;
         sh     <= '1;
         left   <= '0;
      end else if (take) begin
         state  <= TXS_BUSY;
         tx_out <= 1'b0;
         sh     <= nxt;
         left   <= nxt_left;
      end else if (busy && tick) begin
         if (left != '0) begin
            tx_out <= sh[0];
            sh     <= {1'b1, sh[MAXB-1:1]};
            left   <= left - 1'b1;
         end else begin
            state  <= TXS_IDLE;
            tx_out <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx #(
   parameter int DATA_W   = 8,
   parameter int DIV_W    = 8,
   parameter int NINTH_EN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              tx_en,
   input  logic              nine_mode,
   input  logic              ninth_bit,
   input  logic [DIV_W-1:0]  divisor,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              buf_empty,
   output logic              shift_empty,
   output logic              tx_out,
   output logic              tx_drive
);
   generate
      if (DATA_W < 5 || DATA_W > 16) begin : g_bad_data
         $error("dbuf_uart_tx: DATA_W out of range");
      end
      if (DIV_W < 1 || DIV_W > 24) begin : g_bad_div
         $error("dbuf_uart_tx: DIV_W out of range");
      end
      if (NINTH_EN != 0 && NINTH_EN != 1) begin : g_bad_nine
         $error("dbuf_uart_tx: NINTH_EN must be 0 or 1");
      end
   endgenerate

   logic              tick, take, busy, full, clr;
   logic [DATA_W-1:0] hold_q;

   assign clr = !port_en;

   dbtx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .run(busy), .divisor(divisor), .tick(tick)
   );

   dbtx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en && port_en),
      .wr_data(wr_data), .take(take), .full(full), .q(hold_q)
   );

   dbtx_shift #(.DATA_W(DATA_W), .NINTH_EN(NINTH_EN)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
      .load_ok(tx_en && port_en), .hold_full(full), .hold_q(hold_q),
      .nine_mode(nine_mode), .ninth_bit(ninth_bit),
      .take(take), .busy(busy), .tx_out(tx_out)
   );

   assign buf_empty   = !full;
   assign shift_empty = !busy;
   assign tx_drive    = port_en;
endmodule

// File: rtl/dbtx_chk.sv
module dbtx_chk (
   input logic clk,
   input logic rst_n,
   input logic port_en,
   input logic tx_en,
   input logic wr_en,
   input logic buf_empty,
   input logic shift_empty,
   input logic tx_out
);
   a_r2_handoff: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_empty && shift_empty && tx_en && port_en) |=> (buf_empty && !shift_empty));

   a_r3_fill_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(buf_empty) |-> ($past(wr_en) && $past(port_en)));

   a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shift_empty) |-> !tx_out);

   a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      shift_empty |-> tx_out);

   a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> (buf_empty && shift_empty));
endmodule

bind dbuf_uart_tx dbtx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_en(tx_en), .wr_en(wr_en),
   .buf_empty(buf_empty), .shift_empty(shift_empty), .tx_out(tx_out)
);

// File: tb/sim_dbuf_uart_tx.sv
`timescale 1ns/1ps
module sim_dbuf_uart_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       port_en = 1'b0, tx_en = 1'b0, nine_mode = 1'b0, ninth_bit = 1'b0;
   logic [7:0] divisor = 8'd2;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'd0;
   logic       buf_empty, shift_empty, tx_out, tx_drive;

   int total = 0, bad = 0;
   int cyc = 0;
   logic [9:0] exp_q[$];
   int starts[$];
   int frames = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dbuf_uart_tx u0 (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_en(tx_en),
      .nine_mode(nine_mode), .ninth_bit(ninth_bit), .divisor(divisor),
      .wr_en(wr_en), .wr_data(wr_data), .buf_empty(buf_empty),
      .shift_empty(shift_empty), .tx_out(tx_out), .tx_drive(tx_drive)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // driver: pushes the expected frame, then strobes the write
   task automatic send(input logic [7:0] d, input bit expect_it);
      if (expect_it) exp_q.push_back({nine_mode, ninth_bit, d});
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (shift_empty == 1'b0 && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   // monitor: decodes frames at bit centres and compares against the queue
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && port_en && tx_out === 1'b0) begin
            do begin
               automatic int p = int'(divisor) + 1;
               automatic int half = (p - 1) / 2;
               automatic logic [9:0] e;
               automatic int nb;
               automatic logic [8:0] got = '0;
               automatic logic sb, stp;
               starts.push_back(cyc);
               frames++;
               if (exp_q.size() == 0) begin
                  chk(0, "R3 unexpected frame", frames, 0);
                  e = '0;
               end else e = exp_q.pop_front();
               nb = e[9] ? 9 : 8;
               repeat (half) @(negedge clk);
               sb = tx_out;
               for (int i = 0; i < nb; i++) begin
                  repeat (p) @(negedge clk);
                  got[i] = tx_out;
               end
               repeat (p) @(negedge clk);
               stp = tx_out;
               chk(sb == 1'b0, "R4 start bit", sb, 0);
               chk(stp == 1'b1, "R4 stop bit", stp, 1);
               if (nb == 9) chk(got == e[8:0], "R5 nine-bit frame", got, e[8:0]);
               else         chk(got[7:0] == e[7:0], "R4 frame data", got[7:0], e[7:0]);
               repeat (p - 1 - half) @(negedge clk);
            end while (port_en && tx_out === 1'b0);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(0, "watchdog", cyc, 0);
      finish_run();
   end

   initial begin
      int n, s0;
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(buf_empty == 1, "R1 buf_empty", buf_empty, 1);
      chk(shift_empty == 1, "R1 shift_empty", shift_empty, 1);
      chk(tx_out == 1, "R1 tx_out", tx_out, 1);
      chk(tx_drive == 0, "R1 tx_drive", tx_drive, 0);
      rst_n = 1'b1;
      @(negedge clk);
      port_en = 1'b1; tx_en = 1'b1;
      #1 chk(tx_drive == 1, "R9 drive on", tx_drive, 1);
      repeat (2) @(negedge clk);

      // R2 write, hand-off timing, R4 frame length
      divisor = 8'd2;
      send(8'hA5, 1);
      chk(buf_empty == 0, "R2 held", buf_empty, 0);
      @(negedge clk);
      chk(buf_empty == 1, "R2 freed", buf_empty, 1);
      chk(shift_empty == 0, "R2 busy", shift_empty, 0);
      chk(tx_out == 0, "R4 start", tx_out, 0);
      wait_idle(n);
      chk(n == 30, "R4 frame length div2", n, 30);
      chk(tx_out == 1, "R7 idle high", tx_out, 1);

      // R4 other divisors
      divisor = 8'd0;
      send(8'h3C, 1); @(negedge clk); wait_idle(n);
      chk(n == 10, "R4 frame length div0", n, 10);
      divisor = 8'd5;
      send(8'h81, 1); @(negedge clk); wait_idle(n);
      chk(n == 60, "R4 frame length div5", n, 60);

      // R5 nine-bit mode
      divisor = 8'd2; nine_mode = 1'b1; ninth_bit = 1'b1;
      send(8'h00, 1); @(negedge clk); ninth_bit = 1'b0; wait_idle(n);
      chk(n == 33, "R5 frame length", n, 33);
      send(8'hFF, 1); @(negedge clk); wait_idle(n);
      nine_mode = 1'b0;

      // R6 back-to-back, R3 write while full
      s0 = starts.size();
      send(8'h12, 1); @(negedge clk);
      repeat (4) @(negedge clk);
      send(8'h34, 1);
      chk(buf_empty == 0, "R6 second word held", buf_empty, 0);
      send(8'h56, 0);
      chk(buf_empty == 0, "R3 full write ignored", buf_empty, 0);
      wait_idle(n);
      chk(starts.size() == s0 + 2, "R3 frame count", starts.size() - s0, 2);
      if (starts.size() >= s0 + 2)
         chk(starts[s0+1] - starts[s0] == 30, "R6 start spacing",
             starts[s0+1] - starts[s0], 30);
      repeat (3) @(negedge clk);
      chk(buf_empty == 1, "R3 no leftover word", buf_empty, 1);

      // R8 transmit disabled holds the word
      tx_en = 1'b0;
      send(8'h77, 1);
      repeat (20) @(negedge clk);
      chk(shift_empty == 1, "R8 no transfer", shift_empty, 1);
      chk(buf_empty == 0, "R8 word waits", buf_empty, 0);
      tx_en = 1'b1;
      @(negedge clk); wait_idle(n);
      chk(n == 30, "R8 sent after enable", n, 30);

      // R8 disable mid-frame: current frame completes, held word stays
      send(8'h99, 1); @(negedge clk);
      send(8'h66, 0);
      repeat (3) @(negedge clk);
      tx_en = 1'b0;
      wait_idle(n);
      repeat (10) @(negedge clk);
      chk(shift_empty == 1, "R8 frame completed", shift_empty, 1);
      chk(buf_empty == 0, "R8 held word kept", buf_empty, 0);
      exp_q.push_back({2'b00, 8'h66});
      tx_en = 1'b1;
      @(negedge clk); @(negedge clk); wait_idle(n);

      // R9 port disable flushes and blocks writes
      tx_en = 1'b0;
      send(8'h44, 0);
      chk(buf_empty == 0, "R9 pre-flush held", buf_empty, 0);
      port_en = 1'b0;
      #1 chk(tx_drive == 0, "R9 drive off", tx_drive, 0);
      @(negedge clk);
      chk(buf_empty == 1, "R9 flushed", buf_empty, 1);
      send(8'h55, 0);
      chk(buf_empty == 1, "R9 write ignored", buf_empty, 1);
      port_en = 1'b1; tx_en = 1'b1;
      repeat (40) @(negedge clk);
      chk(shift_empty == 1 && tx_out == 1, "R9 nothing sent", tx_out, 1);

      chk(exp_q.size() == 0, "R4 all frames seen", exp_q.size(), 0);
      finish_run();
   end
endmodule